// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This engine takes frames arriving on a byte stream (valid, ready, last) and places each one in host memory through a ring of receive descriptors. The ring has 16 entries by default. Each entry is an 8-byte record: a 16-bit buffer address, a status byte, a high address byte, a negated buffer length, and a 16-bit received-count field. When a frame begins, the engine holds the stream off and reads status bytes, starting at its ring pointer. It takes the first entry whose status byte is exactly 0x80, meaning the host has handed it over. It then streams the frame bytes into that entry's fixed buffer and writes the count field. Last, it writes the status byte as 0x03 (start and end of packet) to return the entry to the host, and emits a one-cycle receive event, with an interrupt pulse when interrupts are enabled.

The memory port is byte-wide and never stalls. A read presents its data on `mem_rdata` in the cycle after the request. Buffer `k` starts at `buf_base + k*BUF_BYTES`, and descriptor `k` starts at `desc_base + 8*k`. A frame that finds no free entry, or that starts while `run` is low, is consumed and thrown away without any memory write. The frame is not validated, filtered or CRC-checked. Each frame always uses exactly one entry.

State machine:
- States: IDLE, PROBE, EXAMINE, FILL, LEN_HI, LEN_LO, HANDBACK and DISCARD.
- IDLE goes to PROBE (start search) on a frame start with `run` high, or to DISCARD (reject stopped) with `run` low.
- PROBE goes to EXAMINE (status read issued).
- EXAMINE goes to FILL (entry claimed), back to PROBE (try next), or to DISCARD (ring exhausted).
- FILL goes to LEN_HI (frame ended) on the last beat.
- LEN_HI goes to LEN_LO (count high written).
- LEN_LO goes to HANDBACK (count low written).
- HANDBACK goes to IDLE (entry returned).
- DISCARD goes to IDLE (frame swallowed) on the last beat.

Top module: `rxr_engine`

## Requirements
- R1: `s_ready` is low in IDLE and throughout the descriptor search. It is high only while a frame is being stored or discarded, so the first beat of every frame waits at least one cycle.
- R2: An entry is claimed only if its status byte (descriptor offset 2) reads exactly 0x80. Any other value, including 0x80 with further bits set, is skipped.
- R3: The search examines entries pointer, pointer+1, … modulo the ring size. It stops before it reaches pointer−1, so at most 15 entries are read. If none qualifies, the whole frame is consumed with no memory write, no event and no pointer change.
- R4: Byte n of a stored frame is written to `buf_base + slot*BUF_BYTES + n`.
- R5: The count field is written as the number of stored bytes plus 4. The high byte goes to descriptor offset 6 and the low byte to offset 7.
- R6: The status byte is written as 0x03, and only after every data byte and both count bytes have been written.
- R7: After a stored frame, the ring pointer grows by exactly one from its old value, whichever entry was claimed.
- R8: `rx_event` pulses for one cycle, together with the status write. `rx_irq` pulses in that same cycle only when `intr_en` is high.
- R9: Only the first BUF_BYTES bytes of a longer frame are written. The remainder is accepted and dropped, and the count reflects the stored bytes.
- R10: A frame that starts while `run` is low is consumed with no memory access, no event and no pointer change.
- R11: After reset the pointer is 0, and `s_ready`, `mem_req` and `rx_event` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Controller running; low rejects new frames |
| intr_en | input | 1 | Enables `rx_irq` |
| desc_base | input | AW | Base byte address of descriptor ring |
| buf_base | input | AW | Base byte address of buffer area |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of frame |
| s_ready | output | 1 | Engine accepts the stream byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| rx_event | output | 1 | One-cycle receive event |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench targets the search boundary. It sweeps a single free entry across all 16 offsets from the pointer. A design that also checked pointer−1 would store a frame the bench expects dropped, and one that stopped early would drop frames it should store. Status bytes near 0x80, such as 0x81 and 0xC0, catch a design that tests only the top bit. Frames of exactly and beyond the buffer size catch writes past the buffer or a wrong count. A frame placed several entries ahead of the pointer, followed by a frame with two candidates, reveals a design that moves the pointer to the claimed slot plus one instead of stepping it by one.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_EXAMINE,
        ST_FILL,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_HANDBACK,
        ST_DISCARD
    } rxr_state_e;

    localparam int DESC_SHIFT   = 3;      // 8-byte descriptors
    localparam int OFS_STATUS   = 2;
    localparam int OFS_CNT_HI   = 6;
    localparam int OFS_CNT_LO   = 7;
    localparam logic [7:0] STATUS_FREE = 8'h80;
    localparam logic [7:0] STATUS_DONE = 8'h03;
    localparam int LEN_BIAS     = 4;

endpackage

// File: rtl/rxr_slot_search.sv
module rxr_slot_search #(
    parameter int RING_LOG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                advance,
    output logic [RING_LOG-1:0] cand,
    output logic [RING_LOG-1:0] ring_ptr,
    output logic                at_end
);
    logic [RING_LOG-1:0] stop_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_ptr <= '0;
            cand     <= '0;
        end else begin
            if (advance)
                ring_ptr <= ring_ptr + 1'b1;
            if (load)
                cand <= ring_ptr;
            else if (step)
                cand <= cand + 1'b1;
        end
    end

    // The search ends when the next candidate would be pointer-1.
    assign stop_idx = ring_ptr - RING_LOG'(2);
    assign at_end   = (cand == stop_idx);

endmodule

// File: rtl/rxr_fill_counter.sv
module rxr_fill_counter #(
    parameter int BUF_BYTES = 1544,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    output logic [CW-1:0] count,
    output logic          full
);
    assign full = (count == CW'(BUF_BYTES));

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (bump && !full)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen
    import rxr_pkg::*;
#(
    parameter int AW        = 24,
    parameter int RING_LOG  = 4,
    parameter int BUF_BYTES = 1544,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input  logic [AW-1:0]       desc_base,
    input  logic [AW-1:0]       buf_base,
    input  logic [RING_LOG-1:0] slot,
    input  logic [CW-1:0]       byte_idx,
    output logic [AW-1:0]       status_addr,
    output logic [AW-1:0]       cnt_hi_addr,
    output logic [AW-1:0]       cnt_lo_addr,
    output logic [AW-1:0]       data_addr
);
    logic [AW-1:0] desc_start;
    logic [AW-1:0] buf_start;

    assign desc_start  = desc_base + (AW'(slot) << DESC_SHIFT);
    assign buf_start   = buf_base + AW'(slot) * AW'(BUF_BYTES);
    assign status_addr = desc_start + AW'(OFS_STATUS);
    assign cnt_hi_addr = desc_start + AW'(OFS_CNT_HI);
    assign cnt_lo_addr = desc_start + AW'(OFS_CNT_LO);
    assign data_addr   = buf_start + AW'(byte_idx);

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int AW        = 24,
    parameter int RING_LOG  = 4,
    parameter int BUF_BYTES = 1544
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          intr_en,
    input  logic [AW-1:0] desc_base,
    input  logic [AW-1:0] buf_base,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          rx_event,
    output logic          rx_irq
);
    localparam int CW = $clog2(BUF_BYTES + 1);

    rxr_state_e          state_q, state_d;
    logic                do_load, do_step, do_advance, do_clear, do_bump;
    logic [RING_LOG-1:0] cand, ring_ptr;
    logic                at_end;
    logic [CW-1:0]       fill_cnt;
    logic                buf_full;
    logic [AW-1:0]       status_addr, cnt_hi_addr, cnt_lo_addr, data_addr;
    logic [15:0]         count_field;

    rxr_slot_search #(.RING_LOG(RING_LOG)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .step     (do_step),
        .advance  (do_advance),
        .cand     (cand),
        .ring_ptr (ring_ptr),
        .at_end   (at_end)
    );

    rxr_fill_counter #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (do_clear),
        .bump  (do_bump),
        .count (fill_cnt),
        .full  (buf_full)
    );

    rxr_addr_gen #(
        .AW(AW), .RING_LOG(RING_LOG), .BUF_BYTES(BUF_BYTES), .CW(CW)
    ) u_addr (
        .desc_base   (desc_base),
        .buf_base    (buf_base),
        .slot        (cand),
        .byte_idx    (fill_cnt),
        .status_addr (status_addr),
        .cnt_hi_addr (cnt_hi_addr),
        .cnt_lo_addr (cnt_lo_addr),
        .data_addr   (data_addr)
    );

    assign count_field = 16'(fill_cnt) + 16'(LEN_BIAS);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d    = state_q;
        do_load    = 1'b0;
        do_step    = 1'b0;
        do_advance = 1'b0;
        do_clear   = 1'b0;
        do_bump    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid) begin
                    if (run) begin
                        state_d  = ST_PROBE;
                        do_load  = 1'b1;
                        do_clear = 1'b1;
                    end else begin
                        state_d = ST_DISCARD;
                    end
                end
            end
            ST_PROBE: begin
                state_d = ST_EXAMINE;
            end
            ST_EXAMINE: begin
                if (mem_rdata == STATUS_FREE) begin
                    state_d = ST_FILL;
                end else if (at_end) begin
                    state_d = ST_DISCARD;
                end else begin
                    state_d = ST_PROBE;
                    do_step = 1'b1;
                end
            end
            ST_FILL: begin
                if (s_valid) begin
                    do_bump = 1'b1;
                    if (s_last)
                        state_d = ST_LEN_HI;
                end
            end
            ST_LEN_HI: begin
                state_d = ST_LEN_LO;
            end
            ST_LEN_LO: begin
                state_d = ST_HANDBACK;
            end
            ST_HANDBACK: begin
                state_d    = ST_IDLE;
                do_advance = 1'b1;
            end
            ST_DISCARD: begin
                if (s_valid && s_last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        s_ready   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_event  = 1'b0;
        rx_irq    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PROBE: begin
                mem_req  = 1'b1;
                mem_addr = status_addr;
            end
            ST_EXAMINE: ;
            ST_FILL: begin
                s_ready   = 1'b1;
                mem_req   = s_valid && !buf_full;
                mem_we    = s_valid && !buf_full;
                mem_addr  = data_addr;
                mem_wdata = s_data;
            end
            ST_LEN_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cnt_hi_addr;
                mem_wdata = count_field[15:8];
            end
            ST_LEN_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cnt_lo_addr;
                mem_wdata = count_field[7:0];
            end
            ST_HANDBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = status_addr;
                mem_wdata = STATUS_DONE;
                rx_event  = 1'b1;
                rx_irq    = intr_en;
            end
            ST_DISCARD: begin
                s_ready = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int RING_LOG  = 4,
    parameter int BUF_BYTES = 1544,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                s_ready,
    input logic                mem_req,
    input logic                mem_we,
    input logic [7:0]          mem_wdata,
    input logic                rx_event,
    input logic                rx_irq,
    input logic                intr_en,
    input rxr_state_e          state_q,
    input logic [CW-1:0]       fill_cnt,
    input logic [RING_LOG-1:0] ring_ptr
);
    // R1: stream accepted only while storing or discarding
    a_r1_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (state_q == ST_FILL || state_q == ST_DISCARD));

    // R6: handback writes the done code
    a_r6_event_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> (mem_req && mem_we && mem_wdata == STATUS_DONE));

    // R6: a write (count low) directly precedes the handback
    a_r6_count_precedes: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> ($past(mem_req) && $past(mem_we)));

    // R7: pointer steps by one after a stored frame
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> (ring_ptr == $past(ring_ptr) + 1'b1));

    // R8: interrupt only with the event and enable
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_event && intr_en));

    // R8: event lasts one cycle
    a_r8_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event);

    // R9: no data write once the buffer is full
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_req) |-> (fill_cnt < CW'(BUF_BYTES)));

    // R3 / R10: discarding never touches memory
    a_r10_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |-> !mem_req);

endmodule

bind rxr_engine rxr_checker #(
    .RING_LOG(RING_LOG), .BUF_BYTES(BUF_BYTES)
) u_rxr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rx_event  (rx_event),
    .rx_irq    (rx_irq),
    .intr_en   (intr_en),
    .state_q   (state_q),
    .fill_cnt  (fill_cnt),
    .ring_ptr  (ring_ptr)
);

// File: tb/rxr_engine_bench.sv
`timescale 1ns/1ps
module rxr_engine_bench;
    localparam int AW    = 10;
    localparam int RL    = 4;
    localparam int NDESC = 16;
    localparam int BUFB  = 16;
    localparam int BBASE = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          intr_en = 1'b0;
    logic [AW-1:0] desc_base = '0;
    logic [AW-1:0] buf_base = AW'(BBASE);
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = '0;
    logic          s_last = 1'b0;
    logic          s_ready;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          rx_event, rx_irq;

    logic [7:0] mem [0:511];
    int nchk = 0;
    int nfail = 0;
    int wr_cnt = 0, ev_cnt = 0, irq_cnt = 0;
    int seq = 0, st_seq = 0, oth_seq = 0;
    int model_ptr = 0;

    always #5 clk = ~clk;

    rxr_engine #(.AW(AW), .RING_LOG(RL), .BUF_BYTES(BUFB)) u_rxr_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .intr_en(intr_en),
        .desc_base(desc_base), .buf_base(buf_base),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_event(rx_event), .rx_irq(rx_irq)
    );

    // Memory model and port monitor
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
                seq <= seq + 1;
                if (int'(mem_addr) < BBASE && mem_addr[2:0] == 3'd2)
                    st_seq <= seq + 1;
                else
                    oth_seq <= seq + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
        if (rx_event) ev_cnt <= ev_cnt + 1;
        if (rx_irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int fid, input int n);
        return 8'(fid * 13 + n * 7 + 1);
    endfunction

    function automatic int find_slot(input int p);
        for (int k = 0; k < NDESC - 1; k++) begin
            int idx;
            idx = (p + k) % NDESC;
            if (mem[idx * 8 + 2] == 8'h80) return idx;
        end
        return -1;
    endfunction

    task automatic set_all(input logic [7:0] v);
        for (int i = 0; i < NDESC; i++) mem[i * 8 + 2] = v;
    endtask

    task automatic set_busy_mix();
        logic [7:0] vals [6] = '{8'h81, 8'hC0, 8'h00, 8'h03, 8'h7F, 8'h84};
        for (int i = 0; i < NDESC; i++) mem[i * 8 + 2] = vals[i % 6];
    endtask

    task automatic send_frame(input int fid, input int len, output bit first_rdy);
        bit took;
        first_rdy = 1'b0;
        for (int n = 0; n < len; n++) begin
            s_valid = 1'b1;
            s_data  = pat(fid, n);
            s_last  = (n == len - 1);
            if (n == 0) first_rdy = s_ready;
            took = 1'b0;
            while (!took) begin
                took = s_ready;
                @(negedge clk);
            end
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic run_frame(input int fid, input int len);
        int slot, stored, w0, e0, i0, s0, cntv;
        bit fr, ok;
        slot = run ? find_slot(model_ptr) : -1;
        stored = (len < BUFB) ? len : BUFB;
        w0 = wr_cnt; e0 = ev_cnt; i0 = irq_cnt; s0 = seq;
        send_frame(fid, len, fr);
        repeat (8) @(negedge clk);
        chk(fr == 1'b0, "R1 first beat held", int'(fr), 0);
        if (slot < 0) begin
            chk(wr_cnt == w0, run ? "R3 dropped frame writes" : "R10 stopped frame writes", wr_cnt - w0, 0);
            chk(ev_cnt == e0, run ? "R3 dropped frame event" : "R10 stopped frame event", ev_cnt - e0, 0);
        end else begin
            chk(wr_cnt - w0 == stored + 3, "R9 write count", wr_cnt - w0, stored + 3);
            ok = 1'b1;
            for (int n = 0; n < stored; n++)
                if (mem[BBASE + slot * BUFB + n] != pat(fid, n)) ok = 1'b0;
            chk(ok, "R4 buffer data", int'(ok), 1);
            cntv = {mem[slot * 8 + 6], mem[slot * 8 + 7]};
            chk(cntv == stored + 4, "R5 count field", cntv, stored + 4);
            chk(mem[slot * 8 + 2] == 8'h03, "R6 status done", int'(mem[slot * 8 + 2]), 3);
            chk(st_seq > oth_seq && st_seq > s0, "R6 status written last", st_seq, oth_seq + 1);
            chk(ev_cnt - e0 == 1, "R8 event count", ev_cnt - e0, 1);
            chk(irq_cnt - i0 == int'(intr_en), "R8 irq count", irq_cnt - i0, int'(intr_en));
            model_ptr = (model_ptr + 1) % NDESC;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int fid;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(s_ready == 1'b0, "R11 ready after reset", int'(s_ready), 0);
        chk(mem_req == 1'b0, "R11 no request after reset", int'(mem_req), 0);
        chk(rx_event == 1'b0, "R11 no event after reset", int'(rx_event), 0);
        run = 1'b1;
        fid = 0;

        // Fill the whole ring, lengths sweep including exact and oversize (R9)
        set_all(8'h80);
        for (int f = 0; f < 17; f++) begin
            intr_en = f[0];
            run_frame(fid, (f * 5) % 21 + 1);
            fid++;
        end

        // R2/R3: a single free entry at every offset from the pointer
        intr_en = 1'b1;
        for (int k = 0; k < NDESC; k++) begin
            set_busy_mix();
            mem[((model_ptr + k) % NDESC) * 8 + 2] = 8'h80;
            run_frame(fid, 3 + k % 4);
            fid++;
        end

        // R7: claim far ahead, then two candidates decide the step
        set_busy_mix();
        mem[((model_ptr + 5) % NDESC) * 8 + 2] = 8'h80;
        run_frame(fid, 4); fid++;
        set_busy_mix();
        mem[(model_ptr % NDESC) * 8 + 2] = 8'h80;
        mem[((model_ptr + 5) % NDESC) * 8 + 2] = 8'h80;
        begin
            int expect_slot;
            expect_slot = model_ptr;
            run_frame(fid, 5); fid++;
            chk(mem[expect_slot * 8 + 2] == 8'h03, "R7 pointer stepped by one", int'(mem[expect_slot * 8 + 2]), 3);
        end

        // R10: stopped controller drops frames, pointer unchanged
        set_all(8'h80);
        run = 1'b0;
        run_frame(fid, 6); fid++;
        run_frame(fid, 1); fid++;
        run = 1'b1;
        begin
            int expect_slot;
            expect_slot = model_ptr;
            run_frame(fid, 2); fid++;
            chk(mem[expect_slot * 8 + 2] == 8'h03, "R10 pointer kept while stopped", int'(mem[expect_slot * 8 + 2]), 3);
        end

        summary();
        $finish;
    end

endmodule